// File: doc/BRIEF.md
# Configurable registered command buffer

This block is the register stage that sits between a memory controller's command and address bus and the devices it feeds. Every rising clock edge it captures a data bus together with three control lines: on-die termination, clock enable and chip select. The captured values drive a set of registered outputs. The width and fan-out are set by two configuration pins. In the wide mode, 25 input lanes map one-to-one onto 25 outputs. In the split mode, 14 lanes are each driven onto an A copy and a B copy. In split mode a second pin selects which group of 14 input lanes feeds the copies: the low lanes 13..0, or the high lanes 24..11.

The ordinary data outputs can be frozen by two active-low select inputs. When both selects are high, the data outputs keep their value. The control outputs are never frozen. An active-low asynchronous reset clears every register and forces every output low. Reset overrides the freeze.

A small state machine fixes the operating mode. While reset is active the machine sits in `ST_BOOT` and follows the configuration pins. The first rising edge after release moves it, according to the pins, into one of three states: `ST_WIDE` (split pin low), `ST_SPLIT_LO` (split pin high, lane-select pin low) or `ST_SPLIT_HI` (both pins high). It stays in that state until the next reset, which is its only exit and returns it to `ST_BOOT`. The edge that leaves `ST_BOOT` captures its data with the newly chosen mode already in effect.

Top module: `regcmd_buffer`

## Requirements
- R1: On each rising clock edge that is not frozen, in wide mode (`cfg_split`=0), `q_a[24:0]` takes the value of `din[24:0]`.
- R2: In wide mode, all B outputs (`q_b`, `odt_b`, `cke_b`, `cs_b_n`) are driven low.
- R3: In split mode (`cfg_split`=1), the selected 14 lanes appear on both `q_a[13:0]` and `q_b[13:0]`, and `q_a[24:14]` is low. With `cfg_lane_hi`=0 the lanes are `din[13:0]`; with `cfg_lane_hi`=1 they are `din[24:11]`, with `din[11]` landing on bit 0. The control outputs are also copied onto `odt_b`, `cke_b` and `cs_b_n`.
- R4: When `dcs_n` and `csr_n` are both 1 at a clock edge, the data outputs keep their previous value. If either is 0, the data outputs update.
- R5: `odt_a`, `cke_a` and `cs_a_n` take `odt_in`, `cke_in` and `dcs_n` at every rising edge after reset, regardless of the freeze condition.
- R6: Driving `rst_n` low clears every output to 0 at once, with no clock edge needed.
- R7: While `rst_n` is low, the outputs stay 0 across clock edges, even when both select inputs are high and the data input is non-zero.
- R8: The mode is taken from the configuration pins only while in reset, or at the first edge after release. Pin changes made after that have no effect until the next reset.
- R9: After reset is released, the outputs remain 0 until an edge captures non-zero values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_split | input | 1 | 0 = 25-lane one-to-one, 1 = 14-lane one-to-two |
| cfg_lane_hi | input | 1 | In split mode, 0 = lanes 13..0, 1 = lanes 24..11 |
| din | input | 25 | Command and address lanes |
| odt_in | input | 1 | Termination control input |
| cke_in | input | 1 | Clock enable input |
| dcs_n | input | 1 | Chip select, active low |
| csr_n | input | 1 | Secondary select, active low; freeze when both selects are high |
| q_a | output | 25 | Registered data, A copy |
| q_b | output | 14 | Registered data, B copy (low in wide mode) |
| odt_a | output | 1 | Registered termination control, A |
| odt_b | output | 1 | Registered termination control, B |
| cke_a | output | 1 | Registered clock enable, A |
| cke_b | output | 1 | Registered clock enable, B |
| cs_a_n | output | 1 | Registered chip select, A |
| cs_b_n | output | 1 | Registered chip select, B |

## Verification
Each data and control result is due exactly one rising edge after its inputs are presented. Every scenario task therefore drives its inputs 2 ns after an edge, waits for the next rising edge, and compares the outputs 2 ns later, before any new stimulus is applied. Reset is the one exception: it is checked 1 ns after `rst_n` falls, with no edge in between, and again after an edge taken while reset is held. Freeze and mode-pin changes are judged by whether the outputs keep the values predicted by the bench.

// File: rtl/regcmd_pkg.sv
package regcmd_pkg;

    typedef enum logic [1:0] {
        ST_BOOT     = 2'd0,
        ST_WIDE     = 2'd1,
        ST_SPLIT_LO = 2'd2,
        ST_SPLIT_HI = 2'd3
    } buf_state_e;

    function automatic buf_state_e pins_to_state(input logic split, input logic lane_hi);
        buf_state_e s;
        if (!split)       s = ST_WIDE;
        else if (lane_hi) s = ST_SPLIT_HI;
        else              s = ST_SPLIT_LO;
        return s;
    endfunction

endpackage

// File: rtl/regcmd_mode_fsm.sv
module regcmd_mode_fsm
    import regcmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_split,
    input  logic       cfg_lane_hi,
    output buf_state_e mode_eff
);

    buf_state_e state_q;
    buf_state_e state_d;
    buf_state_e pin_mode;

    assign pin_mode = pins_to_state(cfg_split, cfg_lane_hi);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_BOOT;
        else        state_q <= state_d;
    end

    // Transitions: boot leaves on the first edge, run states are sticky
    always_comb begin
        unique case (state_q)
            ST_BOOT:     state_d = pin_mode;
            ST_WIDE:     state_d = ST_WIDE;
            ST_SPLIT_LO: state_d = ST_SPLIT_LO;
            ST_SPLIT_HI: state_d = ST_SPLIT_HI;
            default:     state_d = ST_BOOT;
        endcase
    end

    // Output: during boot the pins decide the mode seen by the datapath
    always_comb begin
        unique case (state_q)
            ST_BOOT: mode_eff = pin_mode;
            default: mode_eff = state_q;
        endcase
    end

    AST_MODE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_BOOT) |=> (state_q == $past(state_q))) // R8
        else $error("mode changed after boot");

endmodule

// File: rtl/regcmd_lane_mux.sv
module regcmd_lane_mux
    import regcmd_pkg::*;
#(
    parameter int WIDE_W  = 25,
    parameter int SPLIT_W = 14
) (
    input  buf_state_e        mode,
    input  logic [WIDE_W-1:0] din,
    output logic [WIDE_W-1:0] lanes
);

    localparam int HI_OFS = WIDE_W - SPLIT_W;

    for (genvar i = 0; i < WIDE_W; i++) begin : g_lane
        if (i < SPLIT_W) begin : g_shared
            always_comb begin
                unique case (mode)
                    ST_SPLIT_HI: lanes[i] = din[i + HI_OFS];
                    default:     lanes[i] = din[i];
                endcase
            end
        end else begin : g_wide_only
            always_comb begin
                unique case (mode)
                    ST_SPLIT_LO, ST_SPLIT_HI: lanes[i] = 1'b0;
                    default:                  lanes[i] = din[i];
                endcase
            end
        end
    end

endmodule

// File: rtl/regcmd_hold_reg.sv
module regcmd_hold_reg #(
    parameter int W = 25
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hold,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     q <= '0;
        else if (!hold) q <= d;
    end

    AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> $stable(q)) // R4
        else $error("data moved while frozen");

    AST_DATA_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        !hold |=> (q == $past(d))) // R1
        else $error("data not captured");

endmodule

// File: rtl/regcmd_buffer.sv
module regcmd_buffer
    import regcmd_pkg::*;
#(
    parameter int WIDE_W  = 25,
    parameter int SPLIT_W = 14
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_split,
    input  logic               cfg_lane_hi,
    input  logic [WIDE_W-1:0]  din,
    input  logic               odt_in,
    input  logic               cke_in,
    input  logic               dcs_n,
    input  logic               csr_n,
    output logic [WIDE_W-1:0]  q_a,
    output logic [SPLIT_W-1:0] q_b,
    output logic               odt_a,
    output logic               odt_b,
    output logic               cke_a,
    output logic               cke_b,
    output logic               cs_a_n,
    output logic               cs_b_n
);

    localparam int CTL_W = 3;

    buf_state_e        mode_eff;
    logic [WIDE_W-1:0] lanes;
    logic [WIDE_W-1:0] data_q;
    logic [CTL_W-1:0]  ctl_q;
    logic              freeze;
    logic              split_on;

    assign freeze = dcs_n & csr_n;

    regcmd_mode_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_split   (cfg_split),
        .cfg_lane_hi (cfg_lane_hi),
        .mode_eff    (mode_eff)
    );

    regcmd_lane_mux #(.WIDE_W(WIDE_W), .SPLIT_W(SPLIT_W)) u_mux (
        .mode  (mode_eff),
        .din   (din),
        .lanes (lanes)
    );

    regcmd_hold_reg #(.W(WIDE_W)) u_data (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (freeze),
        .d     (lanes),
        .q     (data_q)
    );

    // Control lines: never frozen
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= {odt_in, cke_in, dcs_n};
    end

    always_comb begin
        unique case (mode_eff)
            ST_SPLIT_LO, ST_SPLIT_HI: split_on = 1'b1;
            default:                  split_on = 1'b0;
        endcase
    end

    assign q_a    = data_q;
    assign q_b    = split_on ? data_q[SPLIT_W-1:0] : '0;
    assign odt_a  = ctl_q[2];
    assign cke_a  = ctl_q[1];
    assign cs_a_n = ctl_q[0];
    assign odt_b  = split_on & ctl_q[2];
    assign cke_b  = split_on & ctl_q[1];
    assign cs_b_n = split_on & ctl_q[0];

    AST_CTRL_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ({odt_a, cke_a, cs_a_n} == $past({odt_in, cke_in, dcs_n}))) // R5
        else $error("control output did not follow input");

    AST_B_MIRRORS_A: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_split == $past(cfg_split)) && split_on |=> (q_b == q_a[SPLIT_W-1:0])) // R3
        else $error("B copy differs from A");

endmodule

// File: tb/tb_regcmd_buffer.sv
module tb_regcmd_buffer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_split = 1'b0;
    logic        cfg_lane_hi = 1'b0;
    logic [24:0] din = '0;
    logic        odt_in = 1'b0;
    logic        cke_in = 1'b0;
    logic        dcs_n = 1'b1;
    logic        csr_n = 1'b1;
    logic [24:0] q_a;
    logic [13:0] q_b;
    logic        odt_a, odt_b, cke_a, cke_b, cs_a_n, cs_b_n;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    regcmd_buffer dut (
        .clk(clk), .rst_n(rst_n), .cfg_split(cfg_split), .cfg_lane_hi(cfg_lane_hi),
        .din(din), .odt_in(odt_in), .cke_in(cke_in), .dcs_n(dcs_n), .csr_n(csr_n),
        .q_a(q_a), .q_b(q_b), .odt_a(odt_a), .odt_b(odt_b), .cke_a(cke_a),
        .cke_b(cke_b), .cs_a_n(cs_a_n), .cs_b_n(cs_b_n)
    );

    task automatic check(input string req, input logic [24:0] ea, input logic [13:0] eb,
                         input logic [5:0] ec);
        logic [5:0] ac;
        ac = {odt_a, odt_b, cke_a, cke_b, cs_a_n, cs_b_n};
        checks++;
        if (q_a !== ea || q_b !== eb || ac !== ec) begin
            errors++;
            $display("FAIL %s: q_a=%h q_b=%h ctl=%b expected q_a=%h q_b=%h ctl=%b",
                     req, q_a, q_b, ac, ea, eb, ec);
        end
    endtask

    task automatic apply(input logic [24:0] d, input logic o, input logic k,
                         input logic s, input logic r);
        din = d; odt_in = o; cke_in = k; dcs_n = s; csr_n = r;
        @(posedge clk);
        #2;
    endtask

    task automatic enter_reset(input logic split, input logic hi);
        rst_n = 1'b0;
        cfg_split = split;
        cfg_lane_hi = hi;
        @(posedge clk);
        #2;
        rst_n = 1'b1;
    endtask

    // R6: outputs low under reset
    task automatic t_reset_state();
        din = 25'h1FFFFFF; odt_in = 1; cke_in = 1; dcs_n = 0; csr_n = 0;
        @(posedge clk);
        #2;
        check("R6 reset state", '0, '0, 6'b0);
    endtask

    // R9, R1, R2, R4 in wide mode
    task automatic t_wide();
        enter_reset(0, 0);
        apply(25'h0, 0, 0, 0, 1);
        check("R9 zero after release", '0, '0, 6'b000000);
        apply(25'h1ABCDEF, 1, 0, 0, 1);
        check("R1 R2 wide capture", 25'h1ABCDEF, '0, 6'b100000);
        apply(25'h0F0F0F0, 0, 1, 1, 0);
        check("R4 csr low updates", 25'h0F0F0F0, '0, 6'b001010);
    endtask

    // R4, R5 freeze with controls moving
    task automatic t_hold();
        apply(25'h1555555, 1, 1, 1, 1);
        check("R4 R5 freeze", 25'h0F0F0F0, '0, 6'b101010);
        apply(25'h0AAAAAA, 0, 0, 1, 1);
        check("R4 R5 freeze again", 25'h0F0F0F0, '0, 6'b000010);
        apply(25'h0AAAAAA, 0, 1, 0, 0);
        check("R4 both low updates", 25'h0AAAAAA, '0, 6'b001000);
    endtask

    // R8: pin change after boot ignored
    task automatic t_mode_locked();
        cfg_split = 1; cfg_lane_hi = 1;
        apply(25'h1FFFFFF, 0, 0, 0, 1);
        check("R8 pins ignored", 25'h1FFFFFF, '0, 6'b000000);
    endtask

    // R6, R7: asynchronous reset beats freeze
    task automatic t_async_reset();
        din = 25'h1234567; odt_in = 1; cke_in = 1; dcs_n = 1; csr_n = 1;
        #1;
        rst_n = 1'b0;
        #1;
        check("R6 R7 async clear", '0, '0, 6'b0);
        @(posedge clk);
        #2;
        check("R7 held through edge", '0, '0, 6'b0);
    endtask

    // R3: split modes, both lane groups
    task automatic t_split(input logic hi);
        logic [24:0] d;
        logic [13:0] sel;
        enter_reset(1, hi);
        d = 25'h1E03A5C;
        sel = hi ? d[24:11] : d[13:0];
        apply(d, 1, 1, 0, 1);
        check(hi ? "R3 split high lanes" : "R3 split low lanes",
              {11'b0, sel}, sel, 6'b111100);
        apply(25'h0C0FFEE, 0, 1, 1, 1);
        check("R3 R4 split freeze", {11'b0, sel}, sel, 6'b001111);
        d = 25'h0C0FFEE;
        sel = hi ? d[24:11] : d[13:0];
        apply(d, 1, 0, 1, 0);
        check("R3 split update", {11'b0, sel}, sel, 6'b110011);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset_state();
        t_wide();
        t_hold();
        t_mode_locked();
        t_async_reset();
        t_split(1'b0);
        t_split(1'b1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule